// File: doc/BRIEF.md
# Interleaved Boost-Inverter Gate Modulator

This block drives the six gates of a three-leg bridge. One leg is a synchronous rectifier that switches at mains frequency. The other two legs are high-frequency inverter legs that also work as two interleaved boost phases. All timing is counted in clock cycles from one shared period counter. The second inverter leg reads that counter shifted by half a period, so the two legs run 180 degrees apart.

A controller supplies four values: the switching period in cycles, a nominal duty as a binary fraction, a dead time in cycles, and the mains polarity bit from an external comparator. While the mains is positive, both inverter legs apply the complement of the nominal duty. While it is negative, they apply the nominal duty itself. The rectifier leg conducts on its low side during positive mains and on its high side during negative mains. Every gate turn-on is separated from the partner gate's turn-off by dead time. The settings are taken in only at a period boundary, so a pulse is never cut short or split by a settings change.

Top module: `ilv_boost_pwm`

## Requirements
- R1: While `rst_n` is low, all six gates are low. After any clock edge at which `enable` is low, all six gates are low. When `enable` is sampled high while the block is idle, that edge starts a new switching period at phase 0.
- R2: Call p the phase, counted in cycles from 0 to P-1 after the period start, where P is the latched period. Leg A's gate outputs follow p with one cycle of latency. The high gate is on for T_dt <= p < T_on and the low gate is on for T_on + T_dt <= p < P. T_dt is the latched dead time and T_on is the latched on-time.
- R3: The nominal on-count is N = floor(P * duty / 2^DUTY_W). With `mains_pos` = 1 (positive mains), T_on = P - N. With `mains_pos` = 0, T_on = N. Both inverter legs use the same T_on.
- R4: T_on is limited to the range [2*T_dt, P - 2*T_dt]; the lower bound is applied first, so the upper bound wins if the two cross. This leaves each gate's on-interval at least one dead time long.
- R5: Leg B uses the rule of R2 with phase (p - floor(P/2)) mod P, so it lags leg A by half a period.
- R6: The rectifier leg turns on its low gate for a latched polarity of 1 and its high gate for a latched polarity of 0. In the first period after enable, and in any period whose latched polarity differs from the previous one, both rectifier gates stay off for p < T_dt.
- R7: The period, duty, dead time and polarity inputs are sampled only at the edge that starts a period. That is the edge at which p = P-1, or the edge that starts the first period after enable. Changes at other times have no effect until the next such edge.
- R8: The two gates of a leg are never on together. A gate turns on only if its partner gate was off in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Gating enable |
| mains_pos | input | 1 | Mains polarity: 1 for positive, 0 for negative |
| period_in | input | PER_W | Switching period in clock cycles |
| duty_in | input | DUTY_W | Nominal duty as a fraction of 2^DUTY_W |
| dead_in | input | DT_W | Dead time in clock cycles, at least 1 |
| rect_hi | output | 1 | Rectifier leg, high-side gate |
| rect_lo | output | 1 | Rectifier leg, low-side gate |
| leg_a_hi | output | 1 | Inverter leg A, high-side gate |
| leg_a_lo | output | 1 | Inverter leg A, low-side gate |
| leg_b_hi | output | 1 | Inverter leg B, high-side gate |
| leg_b_lo | output | 1 | Inverter leg B, low-side gate |

## Verification
The bench builds the block with PER_W = 8, DUTY_W = 6 and DT_W = 4. With these widths every one of the 64 duty codes can be swept at both polarities, and periods of a few dozen cycles keep a full pulse train short. The dead-time range 1 to 7 then reaches both clamp bounds at duty codes 0 and 63. Odd periods exercise the rounded-down half-period offset of leg B. Settings, polarity and enable are also changed in mid-period, which shows that a new setting waits for the boundary and that the interlock holds when leg B's pulse is reshaped partway through its own period.

// File: rtl/ilvp_pkg.sv
package ilvp_pkg;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    localparam int unsigned NUM_INV_LEGS = 2;

endpackage

// File: rtl/ilvp_ontime.sv
module ilvp_ontime #(
    parameter int unsigned PER_W  = 12,
    parameter int unsigned DUTY_W = 8,
    parameter int unsigned DT_W   = 8
) (
    input  logic [PER_W-1:0]  per_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [DT_W-1:0]   dt_i,
    input  logic              pos_i,
    output logic [PER_W-1:0]  on_o
);
    localparam int unsigned XW = PER_W + DUTY_W + DT_W + 2;

    logic [XW-1:0] prod, nom, raw, lo_b, hi_b, lim;

    always_comb begin
        prod = XW'(per_i) * XW'(duty_i);
        nom  = prod >> DUTY_W;
        raw  = pos_i ? (XW'(per_i) - nom) : nom;
        lo_b = XW'(dt_i) << 1;
        hi_b = (XW'(per_i) >= lo_b) ? (XW'(per_i) - lo_b) : '0;
        lim  = raw;
        if (lim < lo_b) lim = lo_b;
        if (lim > hi_b) lim = hi_b;
        on_o = lim[PER_W-1:0];
    end

endmodule

// File: rtl/ilvp_leg_gate.sv
module ilvp_leg_gate
    import ilvp_pkg::*;
#(
    parameter int unsigned PER_W     = 12,
    parameter int unsigned DT_W      = 8,
    parameter int unsigned LAG_HALF  = 0
) (
    input  logic             run_i,
    input  logic [PER_W-1:0] ph_i,
    input  logic [PER_W-1:0] per_i,
    input  logic [PER_W-1:0] on_i,
    input  logic [DT_W-1:0]  dt_i,
    output gate_pair_t       gate_o
);
    localparam int unsigned XW = PER_W + DT_W + 1;

    logic [PER_W-1:0] half, phx;
    logic [XW-1:0]    p, t_on, d, full;

    always_comb begin
        half = per_i >> 1;
        if (LAG_HALF != 0) begin
            phx = (ph_i >= half) ? (ph_i - half) : (ph_i + (per_i - half));
        end else begin
            phx = ph_i;
        end
        p         = XW'(phx);
        t_on      = XW'(on_i);
        d         = XW'(dt_i);
        full      = XW'(per_i);
        gate_o.hi = run_i && (p >= d) && (p < t_on);
        gate_o.lo = run_i && (p >= t_on + d) && (p < full);
    end

endmodule

// File: rtl/ilvp_rect_gate.sv
module ilvp_rect_gate
    import ilvp_pkg::*;
#(
    parameter int unsigned DT_W = 8
) (
    input  logic            run_i,
    input  logic            pos_i,
    input  logic [DT_W-1:0] rdt_i,
    output gate_pair_t      gate_o
);
    logic settled;

    always_comb begin
        settled   = run_i && (rdt_i == '0);
        gate_o.hi = settled && !pos_i;
        gate_o.lo = settled && pos_i;
    end

endmodule

// File: rtl/ilv_boost_pwm.sv
module ilv_boost_pwm
    import ilvp_pkg::*;
#(
    parameter int unsigned PER_W  = 12,
    parameter int unsigned DUTY_W = 8,
    parameter int unsigned DT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              mains_pos,
    input  logic [PER_W-1:0]  period_in,
    input  logic [DUTY_W-1:0] duty_in,
    input  logic [DT_W-1:0]   dead_in,
    output logic              rect_hi,
    output logic              rect_lo,
    output logic              leg_a_hi,
    output logic              leg_a_lo,
    output logic              leg_b_hi,
    output logic              leg_b_lo
);
    typedef struct packed {
        logic                              run;
        logic                              pos;
        logic [PER_W-1:0]                  ph;
        logic [PER_W-1:0]                  per;
        logic [PER_W-1:0]                  on;
        logic [DT_W-1:0]                   dt;
        logic [DT_W-1:0]                   rdt;
        gate_pair_t                        rect;
        gate_pair_t [NUM_INV_LEGS-1:0]     inv;
    } state_t;

    state_t st_d, st_q;

    logic [PER_W-1:0]              on_new;
    gate_pair_t                    rect_raw;
    gate_pair_t [NUM_INV_LEGS-1:0] inv_raw;
    logic                          boundary, fresh;

    ilvp_ontime #(
        .PER_W (PER_W),
        .DUTY_W(DUTY_W),
        .DT_W  (DT_W)
    ) u_ontime (
        .per_i (period_in),
        .duty_i(duty_in),
        .dt_i  (dead_in),
        .pos_i (mains_pos),
        .on_o  (on_new)
    );

    for (genvar g = 0; g < NUM_INV_LEGS; g++) begin : g_leg
        ilvp_leg_gate #(
            .PER_W   (PER_W),
            .DT_W    (DT_W),
            .LAG_HALF(g)
        ) u_leg (
            .run_i (st_q.run),
            .ph_i  (st_q.ph),
            .per_i (st_q.per),
            .on_i  (st_q.on),
            .dt_i  (st_q.dt),
            .gate_o(inv_raw[g])
        );
    end

    ilvp_rect_gate #(
        .DT_W(DT_W)
    ) u_rect (
        .run_i (st_q.run),
        .pos_i (st_q.pos),
        .rdt_i (st_q.rdt),
        .gate_o(rect_raw)
    );

    always_comb begin
        st_d     = st_q;
        boundary = !st_q.run || (st_q.ph >= st_q.per - 1'b1);
        fresh    = !st_q.run || (mains_pos != st_q.pos);

        if (!enable) begin
            st_d.run = 1'b0;
            st_d.ph  = '0;
            st_d.rdt = '0;
        end else if (boundary) begin
            st_d.run = 1'b1;
            st_d.ph  = '0;
            st_d.per = period_in;
            st_d.on  = on_new;
            st_d.dt  = dead_in;
            st_d.pos = mains_pos;
            if (fresh) begin
                st_d.rdt = dead_in;
            end else if (st_q.rdt != '0) begin
                st_d.rdt = st_q.rdt - 1'b1;
            end
        end else begin
            st_d.ph = st_q.ph + 1'b1;
            if (st_q.rdt != '0) st_d.rdt = st_q.rdt - 1'b1;
        end

        if (!enable) begin
            st_d.rect = '0;
            st_d.inv  = '0;
        end else begin
            st_d.rect.hi = rect_raw.hi && !st_q.rect.lo;
            st_d.rect.lo = rect_raw.lo && !st_q.rect.hi;
            for (int i = 0; i < NUM_INV_LEGS; i++) begin
                st_d.inv[i].hi = inv_raw[i].hi && !st_q.inv[i].lo;
                st_d.inv[i].lo = inv_raw[i].lo && !st_q.inv[i].hi;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rect_hi  = st_q.rect.hi;
    assign rect_lo  = st_q.rect.lo;
    assign leg_a_hi = st_q.inv[0].hi;
    assign leg_a_lo = st_q.inv[0].lo;
    assign leg_b_hi = st_q.inv[1].hi;
    assign leg_b_lo = st_q.inv[1].lo;

    // R1
    gates_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !(rect_hi || rect_lo || leg_a_hi || leg_a_lo || leg_b_hi || leg_b_lo));

    // R2
    phase_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.per != '0) |-> (st_q.ph < st_q.per));

    // R6
    rect_follows_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rect_hi |-> !$past(st_q.pos)) and (rect_lo |-> $past(st_q.pos)));

    // R8
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rect_hi && rect_lo) && !(leg_a_hi && leg_a_lo) && !(leg_b_hi && leg_b_lo));

    // R8
    dead_before_a_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(leg_a_lo) |-> !$past(leg_a_hi));

    // R8
    dead_before_b_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(leg_b_hi) |-> !$past(leg_b_lo));

endmodule

// File: tb/test_ilv_boost_pwm.sv
module test_ilv_boost_pwm;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 8;
    localparam int DW = 6;
    localparam int TW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic mains_pos = 1'b1;
    logic [PW-1:0] period_in = 8'd40;
    logic [DW-1:0] duty_in = '0;
    logic [TW-1:0] dead_in = 4'd2;
    logic rect_hi, rect_lo, leg_a_hi, leg_a_lo, leg_b_hi, leg_b_lo;

    int n_vec = 0;
    int n_bad = 0;
    string cur_req = "R1";
    int seed = 7;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilv_boost_pwm #(.PER_W(PW), .DUTY_W(DW), .DT_W(TW)) i_ilv_boost_pwm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mains_pos(mains_pos),
        .period_in(period_in), .duty_in(duty_in), .dead_in(dead_in),
        .rect_hi(rect_hi), .rect_lo(rect_lo), .leg_a_hi(leg_a_hi),
        .leg_a_lo(leg_a_lo), .leg_b_hi(leg_b_hi), .leg_b_lo(leg_b_lo)
    );

    // model state, order of exp: {rect_hi, rect_lo, a_hi, a_lo, b_hi, b_lo}
    int m_run, m_ph, m_per, m_on, m_dt, m_pos, m_fresh;
    logic [5:0] exp_g = '0;

    function automatic int ontime(int p, int d, int t, int pos);
        int nom, r, lo, hi;
        nom = (p * d) >> DW;
        r   = (pos != 0) ? p - nom : nom;
        lo  = 2 * t;
        hi  = (p >= lo) ? p - lo : 0;
        if (r < lo) r = lo;
        if (r > hi) r = hi;
        return r;
    endfunction

    function automatic logic [1:0] leg_raw(int lag);
        int half, phx;
        logic h, l;
        half = m_per / 2;
        if (lag != 0) phx = (m_ph >= half) ? m_ph - half : m_ph + m_per - half;
        else phx = m_ph;
        h = (m_run != 0) && phx >= m_dt && phx < m_on;
        l = (m_run != 0) && phx >= m_on + m_dt && phx < m_per;
        return {h, l};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        logic [5:0] raw;
        logic ok;
        if (!rst_n) begin
            m_run = 0; m_ph = 0; m_per = 0; m_on = 0; m_dt = 0; m_pos = 0; m_fresh = 0;
            exp_g = '0;
        end else begin
            ok = (m_run != 0) && (m_fresh == 0 || m_ph >= m_dt);
            raw = {ok && m_pos == 0, ok && m_pos != 0, leg_raw(0), leg_raw(1)};
            if (!enable) exp_g = '0;
            else exp_g = {raw[5] && !exp_g[4], raw[4] && !exp_g[5],
                          raw[3] && !exp_g[2], raw[2] && !exp_g[3],
                          raw[1] && !exp_g[0], raw[0] && !exp_g[1]};
            if (!enable) begin
                m_run = 0; m_ph = 0;
            end else if (m_run == 0 || m_ph >= m_per - 1) begin
                m_fresh = (m_run == 0 || int'(mains_pos) != m_pos) ? 1 : 0;
                m_run = 1; m_ph = 0;
                m_per = int'(period_in); m_dt = int'(dead_in); m_pos = int'(mains_pos);
                m_on = ontime(m_per, int'(duty_in), m_dt, m_pos);
            end else begin
                m_ph = m_ph + 1;
            end
        end
    end

    task automatic check_vec();
        logic [5:0] got;
        @(negedge clk);
        got = {rect_hi, rect_lo, leg_a_hi, leg_a_lo, leg_b_hi, leg_b_lo};
        n_vec++;
        if (got !== exp_g) begin
            n_bad++;
            $display("FAIL %s: gates actual=%b expected=%b at t=%0t", cur_req, got, exp_g, $time);
        end
        if ((got[5] && got[4]) || (got[3] && got[2]) || (got[1] && got[0])) begin
            n_bad++;
            $display("FAIL R8: overlap actual=%b expected=no overlap", got);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) check_vec();
    endtask

    function automatic int rnd(int m);
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 8) & 32'h7fff) % m;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        run(3);
        rst_n = 1'b1;
        run(3);
        enable = 1'b1;

        // R2 R3 duty sweep at both polarities
        period_in = 8'd40; dead_in = 4'd2;
        for (int pol = 0; pol < 2; pol++) begin
            for (int d = 0; d < 64; d++) begin
                cur_req = (pol == 0) ? "R3 neg R2" : "R3 pos R2";
                mains_pos = pol[0]; duty_in = d[DW-1:0];
                run(80);
            end
        end

        // R4 clamp bounds over dead time range, odd period
        period_in = 8'd45;
        for (int t = 1; t < 8; t++) begin
            for (int e = 0; e < 2; e++) begin
                for (int pol = 0; pol < 2; pol++) begin
                    cur_req = "R4";
                    dead_in = t[TW-1:0]; duty_in = (e == 0) ? 6'd0 : 6'd63;
                    mains_pos = pol[0];
                    run(90);
                end
            end
        end

        // R5 half-period lag, odd and even periods
        dead_in = 4'd3; duty_in = 6'd20;
        for (int p = 33; p < 49; p++) begin
            for (int pol = 0; pol < 2; pol++) begin
                cur_req = "R5";
                period_in = p[PW-1:0]; mains_pos = pol[0];
                run(100);
            end
        end

        // R6 polarity changes at arbitrary points
        period_in = 8'd40; dead_in = 4'd4; duty_in = 6'd30;
        for (int k = 0; k < 20; k++) begin
            cur_req = "R6";
            mains_pos = ~mains_pos;
            run(13 + rnd(50));
        end

        // R7 settings change mid-period
        for (int k = 0; k < 200; k++) begin
            cur_req = "R7";
            period_in = PW'(30 + rnd(30));
            dead_in   = TW'(1 + rnd(7));
            duty_in   = DW'(rnd(64));
            if (rnd(4) == 0) mains_pos = ~mains_pos;
            run(1 + rnd(12));
        end

        // R1 enable gating and restart
        period_in = 8'd36; dead_in = 4'd2; duty_in = 6'd40;
        for (int k = 0; k < 12; k++) begin
            cur_req = "R1";
            enable = 1'b0;
            run(2 + rnd(6));
            enable = 1'b1;
            run(20 + rnd(60));
        end

        summary();
        $finish;
    end

endmodule